// File: doc/BRIEF.md
# Transceiver Host Register Interface

This block sits between a host bus and a two-bus serial transceiver core. The host reaches it with a strobe, a read/write line and a register-select line. With register-select high, the host reaches a 16-bit status-and-mode word. With it low, the host reaches the data path: writes go to the transmit word and reads come from one of the two receive words. The low six bits of the status-and-mode word hold configuration. The bits above them carry live status from the receivers.

Two settings can come from either software or hardware, because each one is the OR of a configuration bit and a dedicated pin. These are the bus used, A or B, and the sync type of a transmitted word, data or command/status. On a transmit write, both ORed values are captured together with the word, and the block gives the encoder a single request pulse. On a read, the block drives the data bus and the sync line together, with one shared output enable, as if they were one 17-bit port.

Top module: `xhr_host_regs`

## Requirements
- R1: While rst_ni is low and after it, the configuration bits are zero, tx_req_o is low, and tx_word_o, tx_bus_o and tx_sync_o are zero.
- R2: On a rising strobe with rd_i=0 and sel_cfg_i=1, configuration bits 5:0 take data_i[5:0]. Bits 15:6 of data_i have no effect.
- R3: While strobe_i=1, rd_i=1 and sel_cfg_i=1, data_o holds the configuration in bits 5:0. Bit 6 is the bus A word flag, bit 7 the bus B word flag and bit 8 the error flag. Bits 15:9 read zero and sync_o is 0.
- R4: On a rising strobe with rd_i=0 and sel_cfg_i=0, tx_req_o is high for exactly the next cycle and tx_word_o takes data_i.
- R5: For that write, tx_bus_o takes configuration bit 5 OR chan_pin_i, sampled at the strobe. A 0 selects bus A and a 1 selects bus B.
- R6: For that write, tx_sync_o takes configuration bit 4 OR sync_pin_i, sampled at the strobe. A 1 selects command/status sync and a 0 selects data sync.
- R7: While strobe_i=1, rd_i=1 and sel_cfg_i=0, data_o and sync_o return the bus A receive word and sync when configuration bit 5 OR chan_pin_i is 0. They return the bus B receive word and sync when it is 1.
- R8: bus_oe_o is high exactly while strobe_i and rd_i are both high, and low otherwise.
- R9: An access acts once per strobe rising edge. Holding the strobe high repeats nothing. Reads never change the configuration and never raise tx_req_o.
- R10: tx_word_o, tx_bus_o and tx_sync_o keep their values until the next transmit write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous master reset |
| strobe_i | input | 1 | Access strobe, active high |
| rd_i | input | 1 | 1 = read, 0 = write |
| sel_cfg_i | input | 1 | 1 = status-and-mode word, 0 = data registers |
| chan_pin_i | input | 1 | Hardware bus select, ORed with configuration bit 5 |
| sync_pin_i | input | 1 | Hardware sync type for writes, ORed with configuration bit 4 |
| data_i | input | 16 | Host write data |
| data_o | output | 16 | Host read data |
| sync_o | output | 1 | Received sync type on data reads |
| bus_oe_o | output | 1 | Output enable for data_o and sync_o |
| rxa_word_i | input | 16 | Bus A receive word |
| rxa_sync_i | input | 1 | Bus A receive sync type |
| rxb_word_i | input | 16 | Bus B receive word |
| rxb_sync_i | input | 1 | Bus B receive sync type |
| rxa_flag_i | input | 1 | Bus A word received |
| rxb_flag_i | input | 1 | Bus B word received |
| err_flag_i | input | 1 | Receive encoding error |
| tx_req_o | output | 1 | One-cycle transmit request |
| tx_word_o | output | 16 | Captured transmit word |
| tx_bus_o | output | 1 | Captured bus select, 0 = A, 1 = B |
| tx_sync_o | output | 1 | Captured sync type, 1 = command/status |

## Verification
The assertions assume that the host holds rd_i, sel_cfg_i, data_i and both pins steady on the cycle of the strobe's rising edge. They also assume that the strobe is low for at least one cycle between accesses. The stimulus meets these assumptions by construction. Every field changes only at a falling clock edge, before the strobe rises. The strobe stays high for two cycles, which also exercises the no-repeat rule, and then stays low for at least one cycle. Random operations, random pin levels and random receive inputs are mixed with directed cases: upper data bits set on a configuration write, pin-only and bit-only selection, and reads between writes.

// File: rtl/xhr_pkg.sv
package xhr_pkg;
  typedef enum logic [1:0] {
    ACC_NONE   = 2'd0,
    ACC_CFG_WR = 2'd1,
    ACC_TX_WR  = 2'd2,
    ACC_RD     = 2'd3
  } acc_e;
endpackage

// File: rtl/xhr_access_dec.sv
module xhr_access_dec
  import xhr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic rd_i,
  input  logic sel_cfg_i,
  output acc_e acc_o,
  output logic oe_o
);
  logic stb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stb_q <= 1'b0;
    else         stb_q <= strobe_i;
  end

  // one action per strobe rising edge
  always_comb begin
    acc_o = ACC_NONE;
    if (strobe_i && !stb_q) begin
      if (rd_i)           acc_o = ACC_RD;
      else if (sel_cfg_i) acc_o = ACC_CFG_WR;
      else                acc_o = ACC_TX_WR;
    end
  end

  assign oe_o = strobe_i & rd_i;
endmodule

// File: rtl/xhr_cfg_reg.sv
module xhr_cfg_reg
  import xhr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CFG_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  acc_e              acc_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CFG_W-1:0]  cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cfg_o <= '0;
    else if (acc_i == ACC_CFG_WR) cfg_o <= data_i[CFG_W-1:0];
  end
endmodule

// File: rtl/xhr_tx_latch.sv
module xhr_tx_latch
  import xhr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  acc_e              acc_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              bus_eff_i,
  input  logic              sync_eff_i,
  output logic              req_o,
  output logic [DATA_W-1:0] word_o,
  output logic              bus_o,
  output logic              sync_o
);
  logic launch;
  assign launch = (acc_i == ACC_TX_WR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o  <= 1'b0;
      word_o <= '0;
      bus_o  <= 1'b0;
      sync_o <= 1'b0;
    end else begin
      req_o <= launch;
      if (launch) begin
        word_o <= data_i;
        bus_o  <= bus_eff_i;
        sync_o <= sync_eff_i;
      end
    end
  end
endmodule

// File: rtl/xhr_rd_mux.sv
module xhr_rd_mux #(
  parameter int DATA_W = 16,
  parameter int CFG_W  = 6
) (
  input  logic              sel_cfg_i,
  input  logic              bus_eff_i,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic              rxa_flag_i,
  input  logic              rxb_flag_i,
  input  logic              err_flag_i,
  input  logic [DATA_W-1:0] rxa_word_i,
  input  logic              rxa_sync_i,
  input  logic [DATA_W-1:0] rxb_word_i,
  input  logic              rxb_sync_i,
  output logic [DATA_W-1:0] data_o,
  output logic              sync_o
);
  localparam int STAT_W = 3;
  localparam int PAD_W  = DATA_W - CFG_W - STAT_W;

  logic [DATA_W-1:0] status_word;

  generate
    if (PAD_W > 0) begin : g_pad
      assign status_word = {{PAD_W{1'b0}}, err_flag_i, rxb_flag_i, rxa_flag_i, cfg_i};
    end else begin : g_nopad
      assign status_word = {err_flag_i, rxb_flag_i, rxa_flag_i, cfg_i};
    end
  endgenerate

  always_comb begin
    if (sel_cfg_i) begin
      data_o = status_word;
      sync_o = 1'b0;
    end else if (bus_eff_i) begin
      data_o = rxb_word_i;
      sync_o = rxb_sync_i;
    end else begin
      data_o = rxa_word_i;
      sync_o = rxa_sync_i;
    end
  end
endmodule

// File: rtl/xhr_host_regs.sv
module xhr_host_regs
  import xhr_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int CFG_W    = 6,
  parameter int BUS_BIT  = 5,
  parameter int SYNC_BIT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic              rd_i,
  input  logic              sel_cfg_i,
  input  logic              chan_pin_i,
  input  logic              sync_pin_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              sync_o,
  output logic              bus_oe_o,
  input  logic [DATA_W-1:0] rxa_word_i,
  input  logic              rxa_sync_i,
  input  logic [DATA_W-1:0] rxb_word_i,
  input  logic              rxb_sync_i,
  input  logic              rxa_flag_i,
  input  logic              rxb_flag_i,
  input  logic              err_flag_i,
  output logic              tx_req_o,
  output logic [DATA_W-1:0] tx_word_o,
  output logic              tx_bus_o,
  output logic              tx_sync_o
);
  acc_e             acc;
  logic [CFG_W-1:0] cfg_q;
  logic             bus_eff;
  logic             sync_eff;

  xhr_access_dec i_dec (
    .clk_i, .rst_ni, .strobe_i, .rd_i, .sel_cfg_i,
    .acc_o(acc), .oe_o(bus_oe_o)
  );

  xhr_cfg_reg #(.DATA_W(DATA_W), .CFG_W(CFG_W)) i_cfg (
    .clk_i, .rst_ni, .acc_i(acc), .data_i, .cfg_o(cfg_q)
  );

  // software bit OR hardware pin
  assign bus_eff  = cfg_q[BUS_BIT]  | chan_pin_i;
  assign sync_eff = cfg_q[SYNC_BIT] | sync_pin_i;

  xhr_tx_latch #(.DATA_W(DATA_W)) i_tx (
    .clk_i, .rst_ni, .acc_i(acc), .data_i,
    .bus_eff_i(bus_eff), .sync_eff_i(sync_eff),
    .req_o(tx_req_o), .word_o(tx_word_o), .bus_o(tx_bus_o), .sync_o(tx_sync_o)
  );

  xhr_rd_mux #(.DATA_W(DATA_W), .CFG_W(CFG_W)) i_rd (
    .sel_cfg_i, .bus_eff_i(bus_eff), .cfg_i(cfg_q),
    .rxa_flag_i, .rxb_flag_i, .err_flag_i,
    .rxa_word_i, .rxa_sync_i, .rxb_word_i, .rxb_sync_i,
    .data_o, .sync_o
  );
endmodule

// File: rtl/xhr_host_regs_chk.sv
module xhr_host_regs_chk #(
  parameter int DATA_W = 16,
  parameter int CFG_W  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              strobe_i,
  input logic              rd_i,
  input logic              sel_cfg_i,
  input logic              chan_pin_i,
  input logic              sync_pin_i,
  input logic [DATA_W-1:0] data_i,
  input logic [DATA_W-1:0] data_o,
  input logic              sync_o,
  input logic              bus_oe_o,
  input logic              rxa_flag_i,
  input logic              rxb_flag_i,
  input logic              err_flag_i,
  input logic              tx_req_o,
  input logic [DATA_W-1:0] tx_word_o,
  input logic              tx_bus_o,
  input logic              tx_sync_o
);
  logic stb_prev;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stb_prev <= 1'b0;
    else         stb_prev <= strobe_i;
  end

  logic tx_wr;
  assign tx_wr = strobe_i && !stb_prev && !rd_i && !sel_cfg_i;

  AST_TX_LAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_wr |=> tx_req_o && tx_word_o == $past(data_i)) else $error("AST_TX_LAUNCH"); // R4
  AST_TX_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o |=> !tx_req_o) else $error("AST_TX_SINGLE"); // R9
  AST_CHAN_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_wr && chan_pin_i) |=> tx_bus_o) else $error("AST_CHAN_PIN"); // R5
  AST_SYNC_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_wr && sync_pin_i) |=> tx_sync_o) else $error("AST_SYNC_PIN"); // R6
  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_wr |=> $stable(tx_word_o) && $stable(tx_bus_o) && $stable(tx_sync_o))
    else $error("AST_TX_HOLD"); // R10
  AST_OE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> !bus_oe_o) else $error("AST_OE_WRITE"); // R8
  AST_STATUS_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && rd_i && sel_cfg_i) |->
      data_o[DATA_W-1:CFG_W+3] == '0 && data_o[CFG_W] == rxa_flag_i &&
      data_o[CFG_W+1] == rxb_flag_i && data_o[CFG_W+2] == err_flag_i && !sync_o)
    else $error("AST_STATUS_RD"); // R3
  AST_NO_TX_FROM_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && rd_i) |=> !tx_req_o) else $error("AST_NO_TX_FROM_RD"); // R9
endmodule

bind xhr_host_regs xhr_host_regs_chk #(.DATA_W(DATA_W), .CFG_W(CFG_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(strobe_i), .rd_i(rd_i),
  .sel_cfg_i(sel_cfg_i), .chan_pin_i(chan_pin_i), .sync_pin_i(sync_pin_i),
  .data_i(data_i), .data_o(data_o), .sync_o(sync_o), .bus_oe_o(bus_oe_o),
  .rxa_flag_i(rxa_flag_i), .rxb_flag_i(rxb_flag_i), .err_flag_i(err_flag_i),
  .tx_req_o(tx_req_o), .tx_word_o(tx_word_o), .tx_bus_o(tx_bus_o),
  .tx_sync_o(tx_sync_o)
);

// File: tb/test_xhr_host_regs.sv
`timescale 1ns/1ps
module test_xhr_host_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strobe = 1'b0, rd = 1'b0, sel = 1'b0, chan = 1'b0, syncp = 1'b0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic        sync_out, oe;
  logic [15:0] rxa_w = '0, rxb_w = '0;
  logic        rxa_s = 1'b0, rxb_s = 1'b0, fa = 1'b0, fb = 1'b0, fe = 1'b0;
  logic        req, tbus, tsync;
  logic [15:0] tword;

  int checks = 0, fails = 0;
  logic [5:0]  m_cfg = '0;
  logic [15:0] m_word = '0;
  logic        m_bus = 1'b0, m_sync = 1'b0;

  always #2 clk = ~clk;

  xhr_host_regs i_xhr_host_regs (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .rd_i(rd), .sel_cfg_i(sel),
    .chan_pin_i(chan), .sync_pin_i(syncp), .data_i(din), .data_o(dout),
    .sync_o(sync_out), .bus_oe_o(oe), .rxa_word_i(rxa_w), .rxa_sync_i(rxa_s),
    .rxb_word_i(rxb_w), .rxb_sync_i(rxb_s), .rxa_flag_i(fa), .rxb_flag_i(fb),
    .err_flag_i(fe), .tx_req_o(req), .tx_word_o(tword), .tx_bus_o(tbus),
    .tx_sync_o(tsync)
  );

  task automatic chk(input string req_id, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req_id, act, exp);
    end
  endtask

  function automatic logic [15:0] status_exp();
    return {7'b0, fe, fb, fa, m_cfg};
  endfunction

  task automatic tx_checks(input string r);
    chk({r, " word"}, 32'(tword), 32'(m_word));
    chk({r, " bus"},  32'(tbus),  32'(m_bus));
    chk({r, " sync"}, 32'(tsync), 32'(m_sync));
  endtask

  // strobe high for two clock edges, low for one
  task automatic access(input logic r, input logic s, input logic [15:0] d,
                        input logic c, input logic sp);
    @(negedge clk);
    rd = r; sel = s; din = d; chan = c; syncp = sp;
    rxa_w = 16'($urandom); rxb_w = 16'($urandom);
    rxa_s = 1'($urandom); rxb_s = 1'($urandom);
    fa = 1'($urandom); fb = 1'($urandom); fe = 1'($urandom);
    strobe = 1'b1;
    #0.5;
    chk("R8 oe", 32'(oe), 32'(r));
    if (r) begin
      if (s) begin
        chk("R3 status", 32'(dout), 32'(status_exp()));
        chk("R3 sync", 32'(sync_out), 32'(0));
      end else if (m_cfg[5] | c) begin
        chk("R7 rxb", {15'b0, rxb_s, dout}, {15'b0, rxb_s, rxb_w});
        chk("R7 rxb sync", 32'(sync_out), 32'(rxb_s));
      end else begin
        chk("R7 rxa", 32'(dout), 32'(rxa_w));
        chk("R7 rxa sync", 32'(sync_out), 32'(rxa_s));
      end
    end
    if (!r && s) m_cfg = d[5:0];
    if (!r && !s) begin
      m_word = d; m_bus = m_cfg[5] | c; m_sync = m_cfg[4] | sp;
    end
    @(negedge clk);
    chk(r ? "R9 no tx on read" : (s ? "R9 no tx on cfg" : "R4 req"),
        32'(req), 32'(!r && !s));
    tx_checks((!r && !s) ? "R4 R5 R6" : "R10");
    @(negedge clk);
    chk("R9 held strobe", 32'(req), 32'(0));
    strobe = 1'b0; rd = 1'b0;
    #0.5;
    chk("R8 oe idle", 32'(oe), 32'(0));
  endtask

  task automatic rd_cfg(input string r);
    @(negedge clk);
    rd = 1'b1; sel = 1'b1; strobe = 1'b1;
    #0.5;
    checks++;
    if (dout[5:0] !== m_cfg) begin
      fails++;
      $display("FAIL %s cfg actual=%h expected=%h", r, dout[5:0], m_cfg);
    end
    @(negedge clk);
    strobe = 1'b0; rd = 1'b0;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #1;
    chk("R1 req in reset", 32'(req), 32'(0));
    tx_checks("R1");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd_cfg("R1");
    // R2 upper bits ignored
    access(1'b0, 1'b1, 16'hFFC0, 1'b0, 1'b0);
    rd_cfg("R2 upper ignored");
    access(1'b0, 1'b1, 16'h002A, 1'b0, 1'b0);
    rd_cfg("R2");
    // R5/R6 pin-only then bit-only
    access(1'b0, 1'b1, 16'h0000, 1'b0, 1'b0);
    access(1'b0, 1'b0, 16'hA5A5, 1'b1, 1'b1);
    access(1'b0, 1'b0, 16'h5A5A, 1'b0, 1'b0);
    access(1'b0, 1'b1, 16'h0030, 1'b0, 1'b0);
    access(1'b0, 1'b0, 16'h1234, 1'b0, 1'b0);
    // R7 pin drives read select
    access(1'b0, 1'b1, 16'h0000, 1'b0, 1'b0);
    access(1'b1, 1'b0, 16'h0000, 1'b0, 1'b0);
    access(1'b1, 1'b0, 16'h0000, 1'b1, 1'b0);
    access(1'b1, 1'b1, 16'hFFFF, 1'b0, 1'b0);
    rd_cfg("R9 read leaves cfg");
    for (int i = 0; i < 400; i++)
      access(1'($urandom), 1'($urandom), 16'($urandom), 1'($urandom), 1'($urandom));
    rd_cfg("R2 final");
    // R1 reset clears cfg and transmit state
    @(negedge clk);
    rst_n = 1'b0;
    m_cfg = '0; m_word = '0; m_bus = 1'b0; m_sync = 1'b0;
    #0.5;
    tx_checks("R1 reset");
    @(negedge clk);
    rst_n = 1'b1;
    rd_cfg("R1 reset cfg");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule